// File: doc/BRIEF.md
# Two-Level Token Readout Arbiter

The block collects hit words from a grid of readout regions, arranged as columns of regions, and places them one at a time on a single shared output bus. A readout sequence starts with a read-enable pulse. At that pulse the block takes a snapshot of the per-region ready flags. It then walks two fixed-priority token chains. A chain inside each column finds that column's first pending region. A chain across the columns, at the periphery, decides which column owns the bus next. Regions whose flag is low are skipped inside the same cycle, so a sequence takes one bus word per ready region and no extra cycles.

Each bus word carries the region's data and its address. The column address and the row address are each written as a thermometer code. Address and data together are protected by a single-error-correcting Hamming code. The output is a valid/ready stream. A word stays on the bus, unchanged, until the consumer accepts it. The next word is loaded in the same cycle that the current one is accepted, so with `out_ready` held high the bus carries one word per clock. When a word first appears, a one-cycle acknowledge strobe tells the served region to release its hit. After the last word is accepted, a one-cycle `done` pulse closes the sequence.

Top module: `token_readout`

## Requirements
- R1: After reset, `out_valid`, `done` and every bit of `rd_ack` are 0.
- R2: A sequence serves exactly the regions whose `region_ready` bit was 1 in the cycle `rd_en` was sampled while idle. A ready flag that rises later is not served in that sequence.
- R3: Words leave in a fixed order: columns in ascending index, and inside a column, regions in ascending row index. Region (c,r) is flag bit c*NREG+r. While `out_ready` stays 1, consecutive words are presented on consecutive cycles with no gap.
- R4: Word format. The payload has the column thermometer in bits [NCOL-2:0], where index c is c low ones. The row thermometer fills the next NREG-1 bits. The region's data (`region_data[(c*NREG+r)*DATA_W +: DATA_W]`) fills the top DATA_W bits. In the codeword, bit p-1 holds Hamming position p. Positions that are powers of two are check bits, each giving even parity over the positions whose index has that bit set. The payload bits fill the remaining positions in ascending order, LSB first.
- R5: Flipping any single bit of a bus word yields a word whose syndrome (the XOR of the set positions) names the flipped position, so the original word is recovered.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_word` unchanged.
- R7: `rd_ack` is zero or one-hot. It pulses bit c*NREG+r only in the first cycle that the word of region (c,r) is on the bus.
- R8: `done` is a one-cycle pulse in the cycle after the last word is accepted. With no ready region, it comes two cycles after the `rd_en` cycle. `out_valid` is 0 whenever `done` is 1.
- R9: `rd_en` asserted while a sequence is active has no effect: the words and their count stay those of the running snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Starts a sequence when idle |
| region_ready | input | NCOL*NREG | Per-region ready flags, bit c*NREG+r |
| region_data | input | NCOL*NREG*DATA_W | Per-region hit data |
| out_valid | output | 1 | Bus word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | CW_W (27 by default) | Hamming-protected address and data word |
| rd_ack | output | NCOL*NREG | One-hot release strobe to the served region |
| done | output | 1 | Sequence finished pulse |

## Verification
The bench builds the block with its default 8 columns of 8 regions and 8-bit data. This gives a 22-bit payload with 5 check bits in a 27-bit word. Both thermometer fields span all 7 of their bits, so index 0 (all zeros) and index 7 (all ones) both occur on the bus. Masks with the first and last regions, single-region and full 64-region masks, and random sparse and dense masks exercise the skipping of empty regions and empty columns. Random back-pressure reaches the hold rule. The full mask drives the longest chain through both token levels.

// File: rtl/readout_pkg.sv
package readout_pkg;

  function automatic int par_bits(input int k);
    int r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if ((1 << r) < k + r + 1) r++;
    end
    return r;
  endfunction

  function automatic int pay_width(input int nc, input int nr, input int dw);
    return dw + (nc - 1) + (nr - 1);
  endfunction

  function automatic int cw_width(input int nc, input int nr, input int dw);
    return pay_width(nc, nr, dw) + par_bits(pay_width(nc, nr, dw));
  endfunction

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [31:0] therm(input int idx);
    return (32'd1 << idx) - 32'd1;
  endfunction

endpackage

// File: rtl/tok_pick.sv
module tok_pick #(
  parameter int W   = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic [W-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [W:0] tok;

  assign tok[0] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_stage
      assign grant[i]  = req[i] & tok[i];
      assign tok[i+1]  = tok[i] & ~req[i];
    end
  endgenerate

  assign any = ~tok[W];

  always_comb begin
    idx = '0;
    for (int k = 0; k < W; k++) begin
      if (grant[k]) idx = idx | IW'(k);
    end
  end
endmodule

// File: rtl/hamming_enc.sv
module hamming_enc #(
  parameter int K  = 22,
  localparam int R = readout_pkg::par_bits(K),
  localparam int N = K + R
) (
  input  logic [K-1:0] payload,
  output logic [N-1:0] code
);
  always_comb begin
    logic [N-1:0] c;
    logic b;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p <= N; p++) begin
      if (!readout_pkg::is_pow2(p)) begin
        c[p-1] = payload[j];
        j++;
      end
    end
    for (int i = 0; i < R; i++) begin
      b = 1'b0;
      for (int p = 1; p <= N; p++) begin
        if (((p >> i) & 1) == 1 && !readout_pkg::is_pow2(p)) b = b ^ c[p-1];
      end
      c[(1 << i) - 1] = b;
    end
    code = c;
  end
endmodule

// File: rtl/token_readout.sv
module token_readout #(
  parameter int NCOL   = 8,
  parameter int NREG   = 8,
  parameter int DATA_W = 8,
  localparam int N     = NCOL * NREG,
  localparam int CW_W  = readout_pkg::cw_width(NCOL, NREG, DATA_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [N-1:0]          region_ready,
  input  logic [N*DATA_W-1:0]   region_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [CW_W-1:0]       out_word,
  output logic [N-1:0]          rd_ack,
  output logic                  done
);
  localparam int PAY_W = readout_pkg::pay_width(NCOL, NREG, DATA_W);
  localparam int CI_W  = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int RI_W  = (NREG > 1) ? $clog2(NREG) : 1;

  logic [N-1:0]     pend_q;
  logic             active_q;
  logic             ov_q;
  logic [CW_W-1:0]  word_q;
  logic [N-1:0]     ack_q;
  logic             done_q;

  logic [NCOL-1:0]  col_any;
  logic [NCOL-1:0]  col_gnt;
  logic [NREG-1:0]  row_gnt [NCOL];
  logic [RI_W-1:0]  row_idx [NCOL];
  logic [CI_W-1:0]  col_idx;
  logic             sel_any;
  logic [N-1:0]     sel_mask;

  genvar c, r;
  generate
    for (c = 0; c < NCOL; c++) begin : g_col
      tok_pick #(.W(NREG)) u_col_chain (
        .req   (pend_q[c*NREG +: NREG]),
        .grant (row_gnt[c]),
        .idx   (row_idx[c]),
        .any   (col_any[c])
      );
      for (r = 0; r < NREG; r++) begin : g_reg
        assign sel_mask[c*NREG + r] = col_gnt[c] & row_gnt[c][r];
      end
    end
  endgenerate

  tok_pick #(.W(NCOL)) u_periph_chain (
    .req   (col_any),
    .grant (col_gnt),
    .idx   (col_idx),
    .any   (sel_any)
  );

  logic [RI_W-1:0]   sel_row;
  logic [DATA_W-1:0] sel_data;
  logic [31:0]       col_th;
  logic [31:0]       row_th;
  logic [PAY_W-1:0]  payload;
  logic [CW_W-1:0]   enc_word;

  always_comb begin
    int flat;
    sel_row  = row_idx[col_idx];
    flat     = int'(col_idx) * NREG + int'(sel_row);
    sel_data = region_data[flat*DATA_W +: DATA_W];
    col_th   = readout_pkg::therm(int'(col_idx));
    row_th   = readout_pkg::therm(int'(sel_row));
    payload  = {sel_data, row_th[NREG-2:0], col_th[NCOL-2:0]};
  end

  hamming_enc #(.K(PAY_W)) u_enc (
    .payload (payload),
    .code    (enc_word)
  );

  logic slot_free, take, finish;
  assign slot_free = !ov_q || out_ready;
  assign take      = active_q && sel_any && slot_free;
  assign finish    = active_q && !sel_any && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      active_q <= 1'b0;
      ov_q     <= 1'b0;
      word_q   <= '0;
      ack_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ack_q  <= '0;
      if (!active_q && rd_en) begin
        pend_q   <= region_ready;
        active_q <= 1'b1;
      end
      if (take) begin
        pend_q <= pend_q & ~sel_mask;
        word_q <= enc_word;
        ov_q   <= 1'b1;
        ack_q  <= sel_mask;
      end else if (ov_q && out_ready) begin
        ov_q <= 1'b0;
      end
      if (finish) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_word  = word_q;
  assign rd_ack    = ack_q;
  assign done      = done_q;
endmodule

// File: rtl/token_readout_checker.sv
module token_readout_checker #(
  parameter int NCOL   = 8,
  parameter int NREG   = 8,
  parameter int DATA_W = 8,
  localparam int N     = NCOL * NREG,
  localparam int CW_W  = readout_pkg::cw_width(NCOL, NREG, DATA_W)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                out_valid,
  input logic                out_ready,
  input logic [CW_W-1:0]     out_word,
  input logic [N-1:0]        rd_ack,
  input logic                done
);
  function automatic int syndrome(input logic [CW_W-1:0] w);
    int s;
    s = 0;
    for (int p = 1; p <= CW_W; p++) if (w[p-1]) s = s ^ p;
    return s;
  endfunction

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_ack)); // R7
  AST_ACK_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_ack) |-> out_valid); // R7
  AST_CODE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> syndrome(out_word) == 0); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid); // R8
endmodule

bind token_readout token_readout_checker #(
  .NCOL(NCOL), .NREG(NREG), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .rd_ack(rd_ack), .done(done)
);

// File: tb/token_readout_tb_top.sv
module token_readout_tb_top;
  localparam int NC = 8;
  localparam int NR = 8;
  localparam int DW = 8;
  localparam int N  = NC * NR;
  localparam int PW = DW + NC - 1 + NR - 1;
  localparam int CW = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en = 1'b0;
  logic [N-1:0]  region_ready = '0;
  logic [N*DW-1:0] region_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [CW-1:0] out_word;
  logic [N-1:0]  rd_ack;
  logic          done;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  token_readout #(.NCOL(NC), .NREG(NR), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .region_ready(region_ready),
    .region_data(region_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .rd_ack(rd_ack), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] encode(input logic [PW-1:0] pay);
    logic [CW-1:0] w;
    int j;
    int s;
    w = '0;
    j = 0;
    for (int p = 1; p <= CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[p-1] = pay[j];
        j++;
      end
    end
    s = 0;
    for (int p = 1; p <= CW; p++) if (w[p-1]) s = s ^ p;
    for (int i = 0; i < 5; i++) if (((s >> i) & 1) == 1) w[(1 << i) - 1] = 1'b1;
    return w;
  endfunction

  function automatic logic [CW-1:0] correct(input logic [CW-1:0] w);
    int s;
    logic [CW-1:0] v;
    v = w;
    s = 0;
    for (int p = 1; p <= CW; p++) if (w[p-1]) s = s ^ p;
    if (s != 0 && s <= CW) v[s-1] = ~v[s-1];
    return v;
  endfunction

  function automatic logic [CW-1:0] expected_word(input int idx);
    int c;
    int r;
    logic [NC-2:0] ct;
    logic [NR-2:0] rt;
    c = idx / NR;
    r = idx % NR;
    ct = '0;
    rt = '0;
    for (int k = 0; k < NC - 1; k++) ct[k] = (k < c);
    for (int k = 0; k < NR - 1; k++) rt[k] = (k < r);
    return encode({region_data[idx*DW +: DW], rt, ct});
  endfunction

  task automatic run_seq(input logic [N-1:0] mask, input int pct, input bit disturb, input bit no_gap);
    int exp_idx[$];
    int got;
    int last_hs;
    int done_cyc;
    bit held;
    logic [CW-1:0] held_word;
    exp_idx = {};
    for (int i = 0; i < N; i++) if (mask[i]) exp_idx.push_back(i);
    got = 0;
    last_hs = 0;
    done_cyc = -1;
    held = 0;
    held_word = '0;
    @(negedge clk);
    region_ready = mask;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (disturb) region_ready = '1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (held) begin
        chk(out_valid && out_word == held_word, "R6 hold under back-pressure", {37'd0, out_word}, {37'd0, held_word});
        held = 0;
      end
      if (done) begin
        done_cyc = cyc;
        break;
      end
      if (rd_ack != '0) begin
        int ai;
        ai = 0;
        for (int i = 0; i < N; i++) if (rd_ack[i]) ai = i;
        chk(out_valid && out_word == expected_word(ai), "R7 ack matches new word", {37'd0, out_word}, {37'd0, expected_word(ai)});
      end
      if (disturb && cyc == 2) rd_en = 1'b1;
      if (disturb && cyc == 3) rd_en = 1'b0;
      out_ready = ($urandom % 100) < pct;
      if (out_valid && !out_ready) begin
        held = 1;
        held_word = out_word;
      end
      if (out_valid && out_ready) begin
        if (got < exp_idx.size()) begin
          logic [CW-1:0] ew;
          bit sec_ok;
          ew = expected_word(exp_idx[got]);
          chk(out_word == ew, "R3/R4 word order and format", {37'd0, out_word}, {37'd0, ew});
          sec_ok = 1;
          for (int b = 0; b < CW; b++) if (correct(out_word ^ (CW'(1) << b)) != out_word) sec_ok = 0;
          chk(sec_ok, "R5 single-bit correction", {37'd0, out_word}, {37'd0, ew});
        end else begin
          chk(0, "R2/R9 extra word beyond snapshot", 64'(got + 1), 64'(exp_idx.size()));
        end
        got++;
        last_hs = cyc;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    rd_en = 1'b0;
    chk(got == exp_idx.size(), "R2/R9 word count", 64'(got), 64'(exp_idx.size()));
    if (exp_idx.size() == 0)
      chk(done_cyc == 1, "R8 done timing empty", 64'(done_cyc), 64'd1);
    else
      chk(done_cyc == last_hs + 1, "R8 done timing", 64'(done_cyc), 64'(last_hs + 1));
    if (no_gap && exp_idx.size() > 0)
      chk(last_hs == exp_idx.size(), "R3 no gap at full rate", 64'(last_hs), 64'(exp_idx.size()));
    @(negedge clk);
    chk(!done && !out_valid, "R8 done one cycle", {62'd0, done, out_valid}, 64'd0);
    region_ready = '0;
  endtask

  task automatic fill_data();
    for (int i = 0; i < N; i++) region_data[i*DW +: DW] = DW'($urandom);
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    logic [N-1:0] m;
    void'($urandom(32'd20240611));
    fill_data();
    repeat (3) @(negedge clk);
    chk(!out_valid && !done && rd_ack == '0, "R1 reset state", {62'd0, out_valid, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done && rd_ack == '0, "R1 idle after reset", 64'(rd_ack), 64'd0);

    // R3 first and last regions plus one in between, full rate
    m = '0; m[0] = 1'b1; m[9] = 1'b1; m[63] = 1'b1;
    run_seq(m, 100, 1'b0, 1'b1);
    // R8 empty sequence
    run_seq('0, 100, 1'b0, 1'b0);
    // R2 and R9: late ready flags and a second rd_en mid-sequence
    m = '0; m[5] = 1'b1; m[20] = 1'b1; m[21] = 1'b1; m[50] = 1'b1;
    run_seq(m, 40, 1'b1, 1'b0);
    // single region in the last column
    m = '0; m[60] = 1'b1;
    run_seq(m, 100, 1'b0, 1'b1);
    // every region, full rate then back-pressured
    fill_data();
    run_seq('1, 100, 1'b0, 1'b1);
    run_seq('1, 50, 1'b0, 1'b0);
    // random masks of varying density
    for (int t = 0; t < 20; t++) begin
      fill_data();
      m = {$urandom, $urandom};
      if (t % 3 == 0) m = m & {$urandom, $urandom} & {$urandom, $urandom};
      run_seq(m, 30 + (t * 7) % 71, (t % 5 == 4), 1'b0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule